// File: doc/BRIEF.md
# Key-Guarded Timekeeping Configuration Controller

This block protects a small bank of timekeeping configuration words: a prescaler word and a calendar load word. A guard register has to receive a two-byte unlock key before any protected write can take effect. Any other value written to the guard register locks the bank again.

The block also runs the freeze handshake for the counters it feeds. Software first sets a freeze request bit. The block then counts slow-clock enable pulses. When the count is done it raises a frozen acknowledge bit and drops its counting enable. While the acknowledge bit is high, the prescaler and calendar words can be loaded. When the request is cleared, counting waits a fixed number of slow ticks before it restarts. At that same tick a synchronised flag goes high, which tells software the calendar outputs can be read again.

The register port has a single write channel. Reads have a registered, one-cycle latency. Register map (2-bit word address): 0 = guard, 1 = status, 2 = prescaler, 3 = calendar load.

Top module: `cfg_guard`

## Requirements
- R1: After reset the bank is locked, the status word reads 0, counting is low, the prescaler reads 0x007F00FF (synchronous divider 255, asynchronous divider 127) and the calendar word reads 0.
- R2: Writing 0xCA and then 0x53 in bits 7:0 of two consecutive guard writes unlocks the bank. Reading the guard address returns 1 in bit 0 while unlocked, otherwise 0.
- R3: While unlocked, any write to the guard address (for example 0xFF) locks the bank.
- R4: If the byte after 0xCA is anything other than 0x53, or if 0x53 comes before 0xCA, the bank stays locked, and a fresh 0xCA, 0x53 pair is needed.
- R5: While locked, writes to the status request bit, the prescaler and the calendar word are ignored with no error.
- R6: Status bit 7 is the freeze request and is writable when unlocked. Status bit 6 (frozen) rises on the second slow tick after the request is set, and counting falls in the same cycle.
- R7: The prescaler and calendar words take writes only when the bank is unlocked and bit 6 is 1. Otherwise they are ignored.
- R8: The prescaler word holds the synchronous divider in bits 14:0 and the asynchronous divider in bits 22:16. All other bits are dropped on write and read back as 0.
- R9: When the request is cleared, bit 6 falls within two clocks. Counting and status bit 5 (synchronised) rise on the fourth slow tick after that.
- R10: Bit 5 clears as soon as a freeze is requested and stays 0 until the restart delay has finished.
- R11: After reset the restart delay applies: counting and bit 5 rise on the fourth slow tick.
- R12: rd_data shows the register selected by rd_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-clock enable marking a slow counting-clock cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Registered read data |
| counting | output | 1 | Counters may advance |
| prediv_sync | output | 15 | Synchronous divider value |
| prediv_async | output | 7 | Asynchronous divider value |
| time_word | output | 32 | Calendar load value |

## Verification
The properties assume that slow_tick is a single-clock pulse and that the bank sees at most one write per clock. The bench keeps to this by raising slow_tick for one clock and then holding it low for at least two clocks. Every write is issued through a task that pulses wr_en for exactly one clock. A near-exhaustive sweep drives all 256 first-key bytes and all 256 second-key bytes. Read-back values are derived in the bench from the stated field positions.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_st_t;
  typedef enum logic [1:0] {MS_RUN, MS_ENTER, MS_FROZEN, MS_LEAVE} mode_st_t;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_GUARD = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 2'd2;
  localparam logic [ADDR_W-1:0] A_TIME  = 2'd3;

  localparam int BIT_REQ  = 7;
  localparam int BIT_ACT  = 6;
  localparam int BIT_SYNC = 5;
  localparam int ASYNC_LSB = 16;
endpackage

// File: rtl/key_gate.sv
module key_gate #(
  parameter logic [7:0] KEY_A = 8'hCA,
  parameter logic [7:0] KEY_B = 8'h53
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_we,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  import cfg_guard_pkg::*;

  key_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= KS_LOCKED;
    end else if (key_we) begin
      unique case (st)
        KS_LOCKED: st <= (key_byte == KEY_A) ? KS_HALF : KS_LOCKED;
        KS_HALF:   st <= (key_byte == KEY_B) ? KS_OPEN : KS_LOCKED;
        default:   st <= KS_LOCKED;
      endcase
    end
  end

  assign unlocked = (st == KS_OPEN);
endmodule

// File: rtl/init_seq.sv
module init_seq #(
  parameter int ENTER_TICKS   = 2,
  parameter int RESTART_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic req_we,
  input  logic req_val,
  output logic init_req,
  output logic init_active,
  output logic regs_synced,
  output logic counting
);
  import cfg_guard_pkg::*;

  localparam int MAXT = (ENTER_TICKS > RESTART_TICKS) ? ENTER_TICKS : RESTART_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ENTER_LAST   = CW'(ENTER_TICKS - 1);
  localparam logic [CW-1:0] RESTART_LAST = CW'(RESTART_TICKS - 1);

  mode_st_t       st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_req <= 1'b0;
    end else if (req_we) begin
      init_req <= req_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= MS_LEAVE;
      cnt         <= '0;
      regs_synced <= 1'b0;
    end else begin
      unique case (st)
        MS_RUN: begin
          if (init_req) begin
            st          <= MS_ENTER;
            cnt         <= '0;
            regs_synced <= 1'b0;
          end
        end
        MS_ENTER: begin
          if (!init_req) begin
            st  <= MS_LEAVE;
            cnt <= '0;
          end else if (slow_tick) begin
            if (cnt == ENTER_LAST) st <= MS_FROZEN;
            else                   cnt <= cnt + 1'b1;
          end
        end
        MS_FROZEN: begin
          if (!init_req) begin
            st  <= MS_LEAVE;
            cnt <= '0;
          end
        end
        default: begin
          if (init_req) begin
            st          <= MS_ENTER;
            cnt         <= '0;
            regs_synced <= 1'b0;
          end else if (slow_tick) begin
            if (cnt == RESTART_LAST) begin
              st          <= MS_RUN;
              regs_synced <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign init_active = (st == MS_FROZEN);
  assign counting    = (st == MS_RUN) || (st == MS_ENTER);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int DW        = 32,
  parameter int SYNC_W    = 15,
  parameter int ASYNC_W   = 7,
  parameter int SYNC_RST  = 255,
  parameter int ASYNC_RST = 127
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               presc_we,
  input  logic               time_we,
  input  logic [DW-1:0]      wdata,
  output logic [SYNC_W-1:0]  prediv_sync,
  output logic [ASYNC_W-1:0] prediv_async,
  output logic [DW-1:0]      time_word
);
  import cfg_guard_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      prediv_sync  <= SYNC_W'(SYNC_RST);
      prediv_async <= ASYNC_W'(ASYNC_RST);
    end else if (presc_we) begin
      prediv_sync  <= wdata[SYNC_W-1:0];
      prediv_async <= wdata[ASYNC_LSB +: ASYNC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_word <= '0;
    end else if (time_we) begin
      time_word <= wdata;
    end
  end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int DW            = 32,
  parameter int SYNC_W        = 15,
  parameter int ASYNC_W       = 7,
  parameter int SYNC_RST      = 255,
  parameter int ASYNC_RST     = 127,
  parameter int ENTER_TICKS   = 2,
  parameter int RESTART_TICKS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             slow_tick,
  input  logic                             wr_en,
  input  logic [cfg_guard_pkg::ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]                    wr_data,
  input  logic [cfg_guard_pkg::ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]                    rd_data,
  output logic                             counting,
  output logic [SYNC_W-1:0]                prediv_sync,
  output logic [ASYNC_W-1:0]               prediv_async,
  output logic [DW-1:0]                    time_word
);
  import cfg_guard_pkg::*;

  logic unlocked, init_req, init_active, regs_synced;
  logic guard_we, stat_we, presc_we, time_we;

  assign guard_we = wr_en && (wr_addr == A_GUARD);
  assign stat_we  = wr_en && (wr_addr == A_STAT)  && unlocked;
  assign presc_we = wr_en && (wr_addr == A_PRESC) && unlocked && init_active;
  assign time_we  = wr_en && (wr_addr == A_TIME)  && unlocked && init_active;

  key_gate u_key (
    .clk(clk), .rst(rst), .key_we(guard_we), .key_byte(wr_data[7:0]),
    .unlocked(unlocked)
  );

  init_seq #(.ENTER_TICKS(ENTER_TICKS), .RESTART_TICKS(RESTART_TICKS)) u_seq (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .req_we(stat_we), .req_val(wr_data[BIT_REQ]),
    .init_req(init_req), .init_active(init_active),
    .regs_synced(regs_synced), .counting(counting)
  );

  cfg_regs #(.DW(DW), .SYNC_W(SYNC_W), .ASYNC_W(ASYNC_W),
             .SYNC_RST(SYNC_RST), .ASYNC_RST(ASYNC_RST)) u_regs (
    .clk(clk), .rst(rst), .presc_we(presc_we), .time_we(time_we),
    .wdata(wr_data), .prediv_sync(prediv_sync),
    .prediv_async(prediv_async), .time_word(time_word)
  );

  logic [DW-1:0] stat_view, presc_view, guard_view;

  always_comb begin
    stat_view            = '0;
    stat_view[BIT_REQ]   = init_req;
    stat_view[BIT_ACT]   = init_active;
    stat_view[BIT_SYNC]  = regs_synced;
    presc_view                       = '0;
    presc_view[SYNC_W-1:0]           = prediv_sync;
    presc_view[ASYNC_LSB +: ASYNC_W] = prediv_async;
    guard_view    = '0;
    guard_view[0] = unlocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        A_GUARD: rd_data <= guard_view;
        A_STAT:  rd_data <= stat_view;
        A_PRESC: rd_data <= presc_view;
        default: rd_data <= time_word;
      endcase
    end
  end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int DW     = 32,
  parameter int SYNC_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              slow_tick,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              unlocked,
  input logic              init_req,
  input logic              init_active,
  input logic              regs_synced,
  input logic              counting,
  input logic [SYNC_W-1:0] prediv_sync,
  input logic [DW-1:0]     time_word
);
  // R10
  sync_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(regs_synced && init_active));

  // R6
  frozen_stops_chk: assert property (@(posedge clk) disable iff (rst)
    init_active |-> !counting);

  // R6
  frozen_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_active) |-> ($past(slow_tick) && init_req));

  // R9
  restart_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(counting) && !init_req) |-> ($past(slow_tick) && regs_synced));

  // R9
  frozen_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_active) |-> !init_req);

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(wr_en && wr_addr == 2'd0 && wr_data[7:0] == 8'h53));

  // R7
  presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 2'd2 && unlocked && init_active) |=> $stable(prediv_sync));

  // R7
  time_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 2'd3 && unlocked && init_active) |=> $stable(time_word));

  // R7
  time_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3 && unlocked && init_active) |=> (time_word == $past(wr_data)));
endmodule

bind cfg_guard cfg_guard_chk #(.DW(DW), .SYNC_W(SYNC_W)) u_chk (
  .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .unlocked(unlocked),
  .init_req(init_req), .init_active(init_active), .regs_synced(regs_synced),
  .counting(counting), .prediv_sync(prediv_sync), .time_word(time_word)
);

// File: tb/tb_cfg_guard.sv
module tb_cfg_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        counting;
  logic [14:0] prediv_sync;
  logic [6:0]  prediv_async;
  logic [31:0] time_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cfg_guard dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .counting(counting), .prediv_sync(prediv_sync),
    .prediv_async(prediv_async), .time_word(time_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic tick();
    @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(2'd0, 32'hCA);
    wr(2'd0, 32'h53);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 registered read
    chk("R1 counting", {31'b0, counting}, 32'd0);
    rd(2'd1, v); chk("R1 status", v, 32'h0);
    rd(2'd0, v); chk("R1 guard", v, 32'h0);
    rd(2'd2, v); chk("R12 presc read", v, 32'h007F00FF);
    rd(2'd3, v); chk("R1 time", v, 32'h0);

    // R11 restart delay after reset
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk("R11 counting", {31'b0, counting}, (i == 4) ? 32'd1 : 32'd0);
    end
    rd(2'd1, v); chk("R11 status sync", v, 32'h20);

    // R5 locked writes ignored
    wr(2'd1, 32'h80);
    rd(2'd1, v); chk("R5 status", v, 32'h20);
    wr(2'd2, 32'h00110022);
    rd(2'd2, v); chk("R5 presc", v, 32'h007F00FF);
    wr(2'd3, 32'hDEADBEEF);
    rd(2'd3, v); chk("R5 time", v, 32'h0);

    // R2 sweep of first key byte
    for (int b = 0; b < 256; b++) begin
      wr(2'd0, 32'(b));
      wr(2'd0, 32'h53);
      rd(2'd0, v); chk("R2 first byte", v, (b == 8'hCA) ? 32'd1 : 32'd0);
      wr(2'd0, 32'h00);
      rd(2'd0, v); chk("R3 relock", v, 32'd0);
    end
    // R4 sweep of second key byte
    for (int b = 0; b < 256; b++) begin
      wr(2'd0, 32'hCA);
      wr(2'd0, 32'(b));
      rd(2'd0, v); chk("R4 second byte", v, (b == 8'h53) ? 32'd1 : 32'd0);
      wr(2'd0, 32'h00);
    end

    // R4 out of order
    wr(2'd0, 32'h53);
    wr(2'd0, 32'hCA);
    rd(2'd0, v); chk("R4 out of order", v, 32'd0);
    wr(2'd0, 32'h53);
    rd(2'd0, v); chk("R4 fresh pair", v, 32'd1);
    wr(2'd0, 32'hFF);
    rd(2'd0, v); chk("R3 FF relocks", v, 32'd0);

    // R7 unlocked but not frozen
    unlock();
    wr(2'd2, 32'h00050006);
    rd(2'd2, v); chk("R7 presc not frozen", v, 32'h007F00FF);

    // R10 / R6 freeze request
    wr(2'd1, 32'h80);
    rd(2'd1, v); chk("R10 sync cleared", v, 32'h80);
    tick();
    rd(2'd1, v); chk("R6 first tick", v, 32'h80);
    chk("R6 counting first tick", {31'b0, counting}, 32'd1);
    tick();
    rd(2'd1, v); chk("R6 frozen", v, 32'hC0);
    chk("R6 counting stopped", {31'b0, counting}, 32'd0);

    // R8 field layout
    wr(2'd2, 32'hFF6483E8);
    rd(2'd2, v); chk("R8 presc layout", v, 32'h006403E8);
    chk("R8 sync out", {17'b0, prediv_sync}, 32'd1000);
    chk("R8 async out", {25'b0, prediv_async}, 32'd100);
    for (int k = 0; k < 8; k++) begin
      pv = (32'(k * 9) << 16) | 32'(k * 1111);
      wr(2'd2, pv | 32'hFF808000);
      rd(2'd2, v); chk("R8 presc sweep", v, pv);
    end
    wr(2'd3, 32'h12345678);
    rd(2'd3, v); chk("R7 time load", v, 32'h12345678);
    chk("R7 time out", time_word, 32'h12345678);

    // R5 relocked while frozen
    wr(2'd0, 32'hFF);
    wr(2'd2, 32'h00010001);
    rd(2'd2, v); chk("R5 presc frozen locked", v, pv);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R5 time frozen locked", v, 32'h12345678);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R5 request kept", v, 32'hC0);

    // R9 leave init
    unlock();
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R9 frozen dropped", v, 32'h0);
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk("R9 counting", {31'b0, counting}, (i == 4) ? 32'd1 : 32'd0);
      rd(2'd1, v); chk("R9 status", v, (i == 4) ? 32'h20 : 32'h0);
    end

    // R10 abort before frozen
    wr(2'd1, 32'h80);
    tick();
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R10 abort status", v, 32'h0);
    for (int i = 1; i <= 4; i++) tick();
    rd(2'd1, v); chk("R9 abort restart", v, 32'h20);
    chk("R9 abort counting", {31'b0, counting}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule